// File: doc/BRIEF.md
# Power-fail store and recall sequencer

This block is the control sequencer of a battery-free nonvolatile SRAM. It samples a digital "supply is above the switch threshold" flag coming from an external comparator, together with the host read and write strobes. Once the supply comes up, it runs a timed recall that copies the nonvolatile image into the SRAM. Once the supply falls, it runs a timed store, but only if the SRAM has taken a write since the last store or recall. If there is nothing to save, it drops straight to the powered-off state.

The sequencer gates host accesses, so reads and writes reach the array only while the array is usable. When a store is triggered, writes stay open for a short grace window so that a write already under way can finish. The block drives a handshake line with a separate output enable. It raises one-cycle start and done pulses toward the array for every recall and every store it performs. All durations are parameters counted in clock cycles.

Top module: `nvseq_top`

## Requirements
- R1: While reset is held, and after it is released with the supply flag low, busy_o, hs_oe_o, arr_rd_o, arr_wr_o and all four pulse outputs are 0, whatever the host strobes do.
- R2: A rising supply flag starts a recall. rcl_start_o pulses SYNC_STAGES+1 cycles after the flag rises. rcl_done_o pulses exactly RECALL_CYC cycles after rcl_start_o.
- R3: If the supply flag falls during a recall, the recall is abandoned. The block returns to the off state with busy_o low, and it gives neither rcl_done_o nor sto_start_o.
- R4: arr_rd_o equals host_rd_i only in the ready state. arr_wr_o equals host_wr_i only in the ready and grace states. Every other strobe is ignored and leaves no trace.
- R5: An accepted write marks the SRAM dirty. A completed store or a completed recall marks it clean.
- R6: If the supply flag falls while the SRAM is clean, no store is started. busy_o stays low and the block returns to the off state.
- R7: If the supply flag falls while the SRAM is dirty, the block enters a grace window of GRACE_CYC cycles in which writes are still accepted. sto_start_o then pulses, and sto_done_o pulses STORE_CYC cycles later.
- R8: A store that has begun is not abandoned if the supply returns. After the store, the block passes through the off state and starts a new recall one cycle after the end of the hold phase.
- R9: hs_oe_o is 1 with hs_o=0 during the grace window. hs_oe_o is 0 during recall and store. hs_oe_o is 1 with hs_o=1 for HOLD_CYC cycles, starting in the cycle of each done pulse.
- R10: busy_o is 1 exactly during recall, grace and store.
- R11: Each pulse output is high for a single cycle, and no two pulse outputs are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pwr_ok_i | input | 1 | Supply-above-threshold flag from the comparator (asynchronous) |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| arr_rd_o | output | 1 | Gated read strobe to the SRAM |
| arr_wr_o | output | 1 | Gated write strobe to the SRAM |
| busy_o | output | 1 | High during recall, grace and store |
| hs_o | output | 1 | Handshake line level (0 = busy, 1 = finished) |
| hs_oe_o | output | 1 | Handshake line drive enable (0 = released) |
| rcl_start_o | output | 1 | One-cycle recall start pulse |
| rcl_done_o | output | 1 | One-cycle recall done pulse |
| sto_start_o | output | 1 | One-cycle store start pulse |
| sto_done_o | output | 1 | One-cycle store done pulse |

## Verification
The power-down path is exercised under three conditions: a clean SRAM, a dirty SRAM with the supply staying low, and a dirty SRAM with the supply returning partway through the store. Between them these separate a skipped store, a store that ends in the off state, and a store followed by a fresh recall. A write is issued while a recall is running and must leave the SRAM clean, which shows that an ignored strobe leaves no trace. A write in the ready state must force the later store. A supply drop inside a recall separates an abandoned recall from one that completes. Every stage length is measured in cycles between the start and done pulses.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_RECALL = 3'd1,
    ST_READY  = 3'd2,
    ST_GRACE  = 3'd3,
    ST_STORE  = 3'd4,
    ST_HOLD   = 3'd5
  } seq_state_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/nvseq_sync.sv
module nvseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) chain_q[0] <= 1'b0;
          else          chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) chain_q[g] <= 1'b0;
          else          chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvseq_dirty.sv
module nvseq_dirty (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  logic dirty_q;
  logic dirty_en;
  logic dirty_d;

  always_comb begin
    dirty_en = set_i || clr_i;
    dirty_d  = !clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)      dirty_q <= 1'b0;
    else if (dirty_en) dirty_q <= dirty_d;
  end

  assign dirty_o = dirty_q;
endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
  import nvseq_pkg::*;
#(
  parameter int RECALL_CYC = 1000,
  parameter int STORE_CYC  = 400,
  parameter int GRACE_CYC  = 2,
  parameter int HOLD_CYC   = 25,
  parameter int W          = 10
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         pwr_ok_i,
  input  logic         dirty_i,
  input  logic         tmr_zero_i,
  output seq_state_e   state_o,
  output logic         tmr_load_o,
  output logic [W-1:0] tmr_val_o,
  output logic         dirty_clr_o,
  output logic         rcl_start_o,
  output logic         rcl_done_o,
  output logic         sto_start_o,
  output logic         sto_done_o
);
  seq_state_e state_q, state_d;
  logic       after_store_q, after_store_d;
  logic       rs_d, rd_d, ss_d, sd_d;
  logic       rs_q, rd_q, ss_q, sd_q;

  always_comb begin
    state_d       = state_q;
    after_store_d = after_store_q;
    tmr_load_o    = 1'b0;
    tmr_val_o     = '0;
    dirty_clr_o   = 1'b0;
    rs_d = 1'b0; rd_d = 1'b0; ss_d = 1'b0; sd_d = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (pwr_ok_i) begin
          state_d    = ST_RECALL;
          tmr_load_o = 1'b1;
          tmr_val_o  = W'(RECALL_CYC - 1);
          rs_d       = 1'b1;
        end
      end
      ST_RECALL: begin
        if (!pwr_ok_i) begin
          state_d = ST_OFF;
        end else if (tmr_zero_i) begin
          state_d       = ST_HOLD;
          after_store_d = 1'b0;
          tmr_load_o    = 1'b1;
          tmr_val_o     = W'(HOLD_CYC - 1);
          dirty_clr_o   = 1'b1;
          rd_d          = 1'b1;
        end
      end
      ST_READY: begin
        if (!pwr_ok_i) begin
          if (dirty_i) begin
            state_d    = ST_GRACE;
            tmr_load_o = 1'b1;
            tmr_val_o  = W'(GRACE_CYC - 1);
          end else begin
            state_d = ST_OFF;
          end
        end
      end
      ST_GRACE: begin
        if (tmr_zero_i) begin
          state_d    = ST_STORE;
          tmr_load_o = 1'b1;
          tmr_val_o  = W'(STORE_CYC - 1);
          ss_d       = 1'b1;
        end
      end
      ST_STORE: begin
        if (tmr_zero_i) begin
          state_d       = ST_HOLD;
          after_store_d = 1'b1;
          tmr_load_o    = 1'b1;
          tmr_val_o     = W'(HOLD_CYC - 1);
          dirty_clr_o   = 1'b1;
          sd_d          = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmr_zero_i) state_d = after_store_q ? ST_OFF : ST_READY;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q       <= ST_OFF;
      after_store_q <= 1'b0;
      rs_q <= 1'b0; rd_q <= 1'b0; ss_q <= 1'b0; sd_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      after_store_q <= after_store_d;
      rs_q <= rs_d; rd_q <= rd_d; ss_q <= ss_d; sd_q <= sd_d;
    end
  end

  assign state_o     = state_q;
  assign rcl_start_o = rs_q;
  assign rcl_done_o  = rd_q;
  assign sto_start_o = ss_q;
  assign sto_done_o  = sd_q;

  // R3: a supply drop inside a recall ends in OFF without a done pulse
  a_r3_recall_abort: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_RECALL && !pwr_ok_i) |=> (state_q == ST_OFF && !rcl_done_o));

  // R8: a running store is held until its timer expires, whatever the supply does
  a_r8_store_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_STORE && !tmr_zero_i) |=> (state_q == ST_STORE));

  // R11: pulses are mutually exclusive
  a_r11_pulse_excl: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0({rs_q, rd_q, ss_q, sd_q}));

  // R11: a start pulse lasts one cycle
  a_r11_start_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rs_q || ss_q) |=> !(rs_q || ss_q));
endmodule

// File: rtl/nvseq_top.sv
module nvseq_top
  import nvseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RECALL_CYC  = 1000,
  parameter int STORE_CYC   = 400,
  parameter int GRACE_CYC   = 2,
  parameter int HOLD_CYC    = 25
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pwr_ok_i,
  input  logic host_rd_i,
  input  logic host_wr_i,
  output logic arr_rd_o,
  output logic arr_wr_o,
  output logic busy_o,
  output logic hs_o,
  output logic hs_oe_o,
  output logic rcl_start_o,
  output logic rcl_done_o,
  output logic sto_start_o,
  output logic sto_done_o
);
  localparam int MAX_CYC = max_of4(RECALL_CYC, STORE_CYC, GRACE_CYC, HOLD_CYC);
  localparam int TW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic [1:0]   rst_sync_q;
  logic         rst_n;
  logic         pwr_ok_s;
  logic         dirty;
  logic         dirty_clr;
  logic         tmr_load;
  logic         tmr_zero;
  logic [TW-1:0] tmr_val;
  seq_state_e   state;
  logic         rd_open, wr_open;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  nvseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_n_i(rst_n), .d_i(pwr_ok_i), .q_o(pwr_ok_s)
  );

  nvseq_timer #(.W(TW)) u_timer (
    .clk_i(clk_i), .rst_n_i(rst_n), .load_i(tmr_load),
    .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  nvseq_dirty u_dirty (
    .clk_i(clk_i), .rst_n_i(rst_n), .set_i(arr_wr_o),
    .clr_i(dirty_clr), .dirty_o(dirty)
  );

  nvseq_fsm #(
    .RECALL_CYC(RECALL_CYC), .STORE_CYC(STORE_CYC), .GRACE_CYC(GRACE_CYC),
    .HOLD_CYC(HOLD_CYC), .W(TW)
  ) u_fsm (
    .clk_i(clk_i), .rst_n_i(rst_n), .pwr_ok_i(pwr_ok_s), .dirty_i(dirty),
    .tmr_zero_i(tmr_zero), .state_o(state), .tmr_load_o(tmr_load),
    .tmr_val_o(tmr_val), .dirty_clr_o(dirty_clr),
    .rcl_start_o(rcl_start_o), .rcl_done_o(rcl_done_o),
    .sto_start_o(sto_start_o), .sto_done_o(sto_done_o)
  );

  // Access gating and handshake decode from the state register
  always_comb begin
    rd_open = rst_n && (state == ST_READY);
    wr_open = rst_n && (state == ST_READY || state == ST_GRACE);
    busy_o  = (state == ST_RECALL) || (state == ST_GRACE) || (state == ST_STORE);
    hs_oe_o = (state == ST_GRACE) || (state == ST_HOLD);
    hs_o    = (state != ST_GRACE);
  end

  assign arr_rd_o = host_rd_i && rd_open;
  assign arr_wr_o = host_wr_i && wr_open;

  // R7: a store only starts while unsaved data is present
  a_r7_store_needs_dirty: assert property (@(posedge clk_i) disable iff (!rst_n)
    sto_start_o |-> dirty);

  // R5: store completion leaves the SRAM clean
  a_r5_clean_after_store: assert property (@(posedge clk_i) disable iff (!rst_n)
    sto_done_o |-> !dirty);

  // R4: no strobe reaches the array while a non-volatile operation runs
  a_r4_no_access_busy: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && !hs_oe_o) |-> (!arr_rd_o && !arr_wr_o));

  // R9: the handshake driver is active during the hold after each done pulse
  a_r9_hold_driven: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rcl_done_o || sto_done_o) |-> (hs_oe_o && hs_o));
endmodule

// File: tb/nvseq_top_tb.sv
module nvseq_top_tb_top;
  localparam int SYNC = 2;
  localparam int RCL  = 20;
  localparam int STO  = 12;
  localparam int GRC  = 3;
  localparam int HLD  = 5;

  logic clk = 1'b0;
  logic rst_n, pwr, hrd, hwr;
  logic ard, awr, busy, hs, hs_oe, rs, rd, ss, sd;
  int total = 0, bad = 0;
  int n_rs = 0, n_rd = 0, n_ss = 0, n_sd = 0;
  logic prev_any = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  nvseq_top #(.SYNC_STAGES(SYNC), .RECALL_CYC(RCL), .STORE_CYC(STO),
              .GRACE_CYC(GRC), .HOLD_CYC(HLD)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .pwr_ok_i(pwr), .host_rd_i(hrd), .host_wr_i(hwr),
    .arr_rd_o(ard), .arr_wr_o(awr), .busy_o(busy), .hs_o(hs), .hs_oe_o(hs_oe),
    .rcl_start_o(rs), .rcl_done_o(rd), .sto_start_o(ss), .sto_done_o(sd)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pulse monitor: counts and R11 width/exclusion checks
  always @(negedge clk) begin
    if (rst_n) begin
      if (rs) n_rs++;
      if (rd) n_rd++;
      if (ss) n_ss++;
      if (sd) n_sd++;
      if ($countones({rs, rd, ss, sd}) > 1) chk("R11 exclusive", $countones({rs, rd, ss, sd}), 1);
      if (prev_any && (rs || rd || ss || sd)) chk("R11 single cycle", 2, 1);
      prev_any <= rs || rd || ss || sd;
    end
  end

  function automatic logic pick(input int sel);
    case (sel)
      0: return rs;
      1: return rd;
      2: return ss;
      default: return sd;
    endcase
  endfunction

  task automatic count_until(input int sel, input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (pick(sel)) begin
        n = k;
        return;
      end
    end
  endtask

  // counts cycles with hs_oe_o driven high, starting at the current sample
  task automatic count_hold(output int h);
    h = 0;
    while (hs_oe_o_now() && h < 100) begin
      if (!hs) chk("R9 hold level", 0, 1);
      h++;
      @(negedge clk);
    end
  endtask

  function automatic logic hs_oe_o_now();
    return hs_oe;
  endfunction

  task automatic t_reset;
    rst_n = 1'b0; pwr = 1'b0; hrd = 1'b1; hwr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 rd gated in reset", ard, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 hs_oe after reset", hs_oe, 0);
    chk("R1 wr gated when off", awr, 0);
    chk("R1 pulses quiet", {rs, rd, ss, sd}, 0);
    hrd = 1'b0; hwr = 1'b0;
  endtask

  task automatic t_powerup(input bit wr_in_recall);
    int n;
    int h;
    pwr = 1'b1;
    count_until(0, 50, n);
    chk("R2 recall start latency", n, SYNC + 1);
    chk("R10 busy in recall", busy, 1);
    chk("R9 released in recall", hs_oe, 0);
    if (wr_in_recall) begin
      hwr = 1'b1; hrd = 1'b1;
      #1;
      chk("R4 write ignored in recall", awr, 0);
      chk("R4 read ignored in recall", ard, 0);
    end
    count_until(1, 100, n);
    hwr = 1'b0; hrd = 1'b0;
    chk("R2 recall duration", n, RCL);
    count_hold(h);
    chk("R9 recall hold length", h, HLD);
    chk("R10 busy low when ready", busy, 0);
    hrd = 1'b1;
    #1;
    chk("R4 read passes when ready", ard, 1);
    hrd = 1'b0;
  endtask

  task automatic t_clean_down;
    int n;
    pwr = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
    chk("R6 no busy on clean drop", busy, 0);
    chk("R6 released on clean drop", hs_oe, 0);
    hwr = 1'b1;
    #1;
    chk("R4 write ignored when off", awr, 0);
    hwr = 1'b0;
    count_until(2, 40, n);
    chk("R6 no store when clean", n, -1);
  endtask

  task automatic t_dirty_down(input bit pwr_back);
    int n;
    int h;
    hwr = 1'b1;
    #1;
    chk("R4 write passes when ready", awr, 1);
    @(negedge clk);
    hwr = 1'b0;
    pwr = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
    chk("R10 busy in grace", busy, 1);
    chk("R9 driven in grace", hs_oe, 1);
    chk("R9 level low in grace", hs, 0);
    hwr = 1'b1;
    #1;
    chk("R7 write open in grace", awr, 1);
    count_until(2, 50, n);
    hwr = 1'b0;
    chk("R7 grace length", n, GRC);
    chk("R9 released in store", hs_oe, 0);
    if (pwr_back) begin
      repeat (4) @(negedge clk);
      pwr = 1'b1;
      count_until(3, 100, n);
      chk("R8 store completes despite supply", n, STO - 4);
    end else begin
      count_until(3, 100, n);
      chk("R7 store duration", n, STO);
    end
    count_hold(h);
    chk("R9 store hold length", h, HLD);
    if (pwr_back) begin
      count_until(0, 10, n);
      chk("R8 recall after store", n, 1);
      count_until(1, 100, n);
      chk("R2 recall duration after store", n, RCL);
      count_hold(h);
      chk("R9 hold after second recall", h, HLD);
    end else begin
      chk("R7 off after store", busy, 0);
    end
  endtask

  task automatic t_abort;
    int n;
    pwr = 1'b1;
    count_until(0, 50, n);
    chk("R3 recall started", n, SYNC + 1);
    repeat (5) @(negedge clk);
    pwr = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
    chk("R3 busy low after abort", busy, 0);
    count_until(1, RCL + 10, n);
    chk("R3 no recall done", n, -1);
  endtask

  initial begin
    t_reset();
    t_powerup(1'b1);     // write during recall must not mark dirty
    t_clean_down();      // R5: still clean, so no store
    t_powerup(1'b0);
    t_dirty_down(1'b0);  // R5: accepted write forces a store
    t_powerup(1'b0);
    t_dirty_down(1'b1);  // store, then recall with supply back
    t_clean_down();      // R5: store and recall left the SRAM clean
    t_abort();
    repeat (3) @(negedge clk);
    chk("R11 recall start count", n_rs, 5);
    chk("R11 recall done count", n_rd, 4);
    chk("R11 store start count", n_ss, 2);
    chk("R11 store done count", n_sd, 2);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule